// File: doc/BRIEF.md
# Program-Memory Block Write Controller

This controller sits between a CPU register bus and a program memory that can only be erased and rewritten one aligned group of four 14-bit words at a time. Software sets an address and a data word through byte-wide registers, opens a two-key unlock handshake and then sets a write bit. For the first three word positions of a group, the word only goes into a four-slot staging buffer. When the word at position three is written, the controller erases the whole group and then programs all four staged words in one pass. The CPU is held off for the length of that commit.

The write bit is only accepted after a fixed sequence: the program-select bit, then 55h and AAh to the key register with nothing in between, then a control write with the program-select and write bits set. Two configuration bits mark a low segment of memory as protected, and writes aimed there are dropped. An accepted write captures its address and data when it is started. The effect lands two clock cycles later, which leaves room for the two idle instruction slots after the control write.

Top module: `pmw_blockwrite`

## Requirements
- R1: After reset, stall, wr_busy, done, mem_erase and mem_prog are all low, and every buffer slot holds 3FFFh.
- R2: Register select codes are 0 address low (8 bits), 1 address high (bits 4:0 used), 2 data low (8 bits), 3 data high (bits 5:0 used), 4 control (bit 7 program select, bit 1 write) and 5 key. A write is started only when a control write has bit 7 and bit 1 set, the stored program-select bit is already 1, and the two writes just before it were 55h and then AAh to the key register.
- R3: A key value other than the expected one, or a write to any other register between the key writes, cancels the unlock, and the following write bit has no effect.
- R4: An accepted write to word position 0, 1 or 2 (address bits 1:0) raises wr_busy for exactly two cycles and loads the buffer slot with that index, with no stall and no memory command.
- R5: An accepted write to position 3 loads slot 3, then pulses mem_erase in the first stall cycle and mem_prog in the last. Both carry mem_blk_addr equal to the address with bits 1:0 cleared. mem_blk_data holds slot k in bits 14k+13 down to 14k.
- R6: For a position-3 write, stall is high for exactly STALL_CYC cycles, starting two cycles after the control write is taken. wr_busy stays high from the control write to the end of the stall.
- R7: done goes high when a commit finishes and stays high until the next accepted write starts.
- R8: Write protection by wp_cfg: 0 protects nothing, 1 protects addresses 000h to 0FFh, 2 protects 0000h to 0FFFh, 3 protects all. A write aimed at a protected address is ignored.
- R9: An accepted write uses the address and data held when the control write is taken. Data register writes during the setup cycles do not change the stored word.
- R10: Setting the write bit while an operation is in progress, even after a valid unlock, starts nothing.
- R11: Each buffer slot keeps its last loaded word across commits. A slot never loaded since reset is committed as 3FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| wp_cfg | input | 2 | Write-protect configuration |
| stall | output | 1 | CPU hold during the erase and program commit |
| wr_busy | output | 1 | Write bit: set from start until the operation ends |
| done | output | 1 | Set after a completed commit |
| mem_erase | output | 1 | One-cycle block erase command |
| mem_prog | output | 1 | One-cycle block program command |
| mem_blk_addr | output | 13 | Block base address for the memory commands |
| mem_blk_data | output | 56 | Four staged words, slot 0 in the low bits |

## Verification
Two activities can share a cycle here. The buffer slot load at the end of the setup window can coincide with the CPU writing the data registers again, and a new unlock plus write bit can arrive while a commit is running. The bench writes fresh data values in the two setup cycles and checks that the committed block holds the word captured at the control write. It then sends a full unlock and write-bit sequence that lands in the stall window, and checks that exactly one erase occurs and that wr_busy stays low afterwards.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    localparam int ADDR_W = 13;
    localparam int WORD_W = 14;
    localparam int LO_W   = 8;
    localparam int HI_W   = WORD_W - LO_W;
    localparam int AHI_W  = ADDR_W - LO_W;
    localparam int SLOTS  = 4;
    localparam int OFF_W  = $clog2(SLOTS);
    localparam int SEL_W  = 3;

    localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam int CTL_PGM_BIT = 7;
    localparam int CTL_WR_BIT  = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALO = 3'd0,
        SEL_AHI = 3'd1,
        SEL_DLO = 3'd2,
        SEL_DHI = 3'd3,
        SEL_CTL = 3'd4,
        SEL_KEY = 3'd5
    } regsel_e;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_OPEN
    } unlock_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_COMMIT
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
    } req_t;

    function automatic logic wp_hit(input logic [ADDR_W-1:0] a, input logic [1:0] wp);
        logic hit;
        case (wp)
            2'd0:    hit = 1'b0;
            2'd1:    hit = (a[ADDR_W-1:8] == '0);
            2'd2:    hit = !a[ADDR_W-1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pmw_unlock.sv
module pmw_unlock
    import pmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic             opened
);

    unlock_e st, st_nx;

    always_comb begin
        st_nx = st;
        if (reg_we) begin
            if (reg_sel == SEL_KEY) begin
                if (st == UL_IDLE && reg_wdata == KEY_FIRST)
                    st_nx = UL_HALF;
                else if (st == UL_HALF && reg_wdata == KEY_SECOND)
                    st_nx = UL_OPEN;
                else
                    st_nx = UL_IDLE;
            end else begin
                st_nx = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= UL_IDLE;
        else     st <= st_nx;
    end

    assign opened = (st == UL_OPEN);

endmodule

// File: rtl/pmw_wbuf.sv
module pmw_wbuf
    import pmw_pkg::*;
#(
    parameter int NSLOT = SLOTS,
    localparam int SW = $clog2(NSLOT)
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [SW-1:0]           slot,
    input  logic [WORD_W-1:0]       word,
    output logic [NSLOT*WORD_W-1:0] flat
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= ERASED;
            else if (load && slot == SW'(s))
                q <= word;
        end
        assign flat[s*WORD_W +: WORD_W] = q;
    end

endmodule

// File: rtl/pmw_seq.sv
module pmw_seq
    import pmw_pkg::*;
#(
    parameter int STALL_CYC = 16,
    parameter int SETUP_CYC = 2,
    localparam int TOP = (STALL_CYC > SETUP_CYC) ? STALL_CYC : SETUP_CYC,
    localparam int CW  = $clog2(TOP + 1)
)(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_last,
    output logic load,
    output logic busy,
    output logic in_commit,
    output logic erase_cmd,
    output logic prog_cmd,
    output logic done
);

    phase_e        ph;
    logic [CW-1:0] cnt;
    logic          last_q;

    wire setup_end  = (ph == PH_SETUP)  && (cnt == CW'(SETUP_CYC - 1));
    wire commit_end = (ph == PH_COMMIT) && (cnt == CW'(STALL_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            cnt    <= '0;
            last_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph     <= PH_SETUP;
                        cnt    <= '0;
                        last_q <= start_last;
                        done   <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (setup_end) begin
                        cnt <= '0;
                        ph  <= last_q ? PH_COMMIT : PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_COMMIT: begin
                    if (commit_end) begin
                        cnt  <= '0;
                        ph   <= PH_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign load      = setup_end;
    assign busy      = (ph != PH_IDLE);
    assign in_commit = (ph == PH_COMMIT);
    assign erase_cmd = in_commit && (cnt == '0);
    assign prog_cmd  = commit_end;

endmodule

// File: rtl/pmw_blockwrite.sv
module pmw_blockwrite
    import pmw_pkg::*;
#(
    parameter int STALL_CYC = 16
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [SEL_W-1:0]        reg_sel,
    input  logic [7:0]              reg_wdata,
    input  logic [1:0]              wp_cfg,
    output logic                    stall,
    output logic                    wr_busy,
    output logic                    done,
    output logic                    mem_erase,
    output logic                    mem_prog,
    output logic [ADDR_W-1:0]       mem_blk_addr,
    output logic [SLOTS*WORD_W-1:0] mem_blk_data
);

    logic [LO_W-1:0]  alo, dlo;
    logic [AHI_W-1:0] ahi;
    logic [HI_W-1:0]  dhi;
    logic             pgm_sel;
    req_t             req;
    logic             opened, start, load, busy;

    wire [ADDR_W-1:0] cur_addr = {ahi, alo};

    always_ff @(posedge clk) begin
        if (rst) begin
            alo     <= '0;
            ahi     <= '0;
            dlo     <= '0;
            dhi     <= '0;
            pgm_sel <= 1'b0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_ALO: alo     <= reg_wdata;
                SEL_AHI: ahi     <= reg_wdata[AHI_W-1:0];
                SEL_DLO: dlo     <= reg_wdata;
                SEL_DHI: dhi     <= reg_wdata[HI_W-1:0];
                SEL_CTL: pgm_sel <= reg_wdata[CTL_PGM_BIT];
                default: ;
            endcase
        end
    end

    pmw_unlock u_unlock (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .opened    (opened)
    );

    assign start = reg_we && (reg_sel == SEL_CTL) && opened && pgm_sel
                && reg_wdata[CTL_PGM_BIT] && reg_wdata[CTL_WR_BIT]
                && !busy && !wp_hit(cur_addr, wp_cfg);

    always_ff @(posedge clk) begin
        if (rst)
            req <= '0;
        else if (start)
            req <= '{addr: cur_addr, word: {dhi, dlo}};
    end

    pmw_seq #(.STALL_CYC(STALL_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_last (cur_addr[OFF_W-1:0] == OFF_W'(SLOTS - 1)),
        .load       (load),
        .busy       (busy),
        .in_commit  (stall),
        .erase_cmd  (mem_erase),
        .prog_cmd   (mem_prog),
        .done       (done)
    );

    pmw_wbuf #(.NSLOT(SLOTS)) u_wbuf (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .slot (req.addr[OFF_W-1:0]),
        .word (req.word),
        .flat (mem_blk_data)
    );

    assign wr_busy      = busy;
    assign mem_blk_addr = {req.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/pmw_blockwrite_chk.sv
module pmw_blockwrite_chk
    import pmw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              wr_busy,
    input logic              done,
    input logic              mem_erase,
    input logic              mem_prog,
    input logic [ADDR_W-1:0] mem_blk_addr
);

    // R5: an erase is only issued inside the stall window
    a_r5_erase_in_stall: assert property (@(posedge clk) disable iff (rst)
        mem_erase |-> stall);

    // R5: a stall opens with the erase command
    a_r5_stall_starts_erase: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> mem_erase);

    // R5: erase and program never share a cycle
    a_r5_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_erase, mem_prog}));

    // R6: stall implies the write bit is still set
    a_r6_stall_busy: assert property (@(posedge clk) disable iff (rst)
        stall |-> wr_busy);

    // R6: block address held steady through the commit
    a_r6_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (stall && $past(stall)) |-> $stable(mem_blk_addr));

    // R7: the end of a stall leaves done set
    a_r7_done_after_commit: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> done);

    // R5: program command is the final stall cycle
    a_r5_prog_ends_stall: assert property (@(posedge clk) disable iff (rst)
        mem_prog |=> !stall);

endmodule

bind pmw_blockwrite pmw_blockwrite_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .wr_busy      (wr_busy),
    .done         (done),
    .mem_erase    (mem_erase),
    .mem_prog     (mem_prog),
    .mem_blk_addr (mem_blk_addr)
);

// File: tb/pmw_blockwrite_test.sv
module pmw_blockwrite_test;

    localparam int PERIOD = 10;
    localparam int STALL  = 12;
    localparam int NV     = 10;

    // {address, word, wp_cfg, sequence mode}
    // mode 0 good, 1 wrong second key, 2 register write between keys, 3 select bit clear
    localparam logic [30:0] VEC [NV] = '{
        {13'h0100, 14'h1234, 2'd0, 2'd0},
        {13'h0101, 14'h0ABC, 2'd0, 2'd0},
        {13'h0102, 14'h3001, 2'd0, 2'd1},
        {13'h0103, 14'h2222, 2'd0, 2'd0},
        {13'h0202, 14'h1111, 2'd1, 2'd0},
        {13'h0050, 14'h0777, 2'd1, 2'd0},
        {13'h0203, 14'h0333, 2'd0, 2'd2},
        {13'h0203, 14'h0444, 2'd0, 2'd3},
        {13'h0203, 14'h0555, 2'd0, 2'd0},
        {13'h1FFF, 14'h0001, 2'd2, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  wp_cfg = '0;
    logic        stall, wr_busy, done, mem_erase, mem_prog;
    logic [12:0] mem_blk_addr;
    logic [55:0] mem_blk_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          n_erase = 0;
    int          n_prog = 0;
    logic [12:0] er_addr = '0;
    logic [12:0] pg_addr = '0;
    logic [55:0] pg_data = '0;
    logic [13:0] exp_buf [4];

    always #(PERIOD/2) clk = ~clk;

    pmw_blockwrite #(.STALL_CYC(STALL)) uut (
        .clk          (clk),
        .rst          (rst),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .wp_cfg       (wp_cfg),
        .stall        (stall),
        .wr_busy      (wr_busy),
        .done         (done),
        .mem_erase    (mem_erase),
        .mem_prog     (mem_prog),
        .mem_blk_addr (mem_blk_addr),
        .mem_blk_data (mem_blk_data)
    );

    always @(posedge clk) begin
        if (mem_erase) begin
            n_erase++;
            er_addr = mem_blk_addr;
        end
        if (mem_prog) begin
            n_prog++;
            pg_addr = mem_blk_addr;
            pg_data = mem_blk_data;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_word(input logic [12:0] a, input logic [13:0] w, input logic [1:0] mode);
        wr(3'd0, a[7:0]);
        wr(3'd1, {3'b000, a[12:8]});
        wr(3'd2, w[7:0]);
        wr(3'd3, {2'b00, w[13:8]});
        wr(3'd4, (mode == 2'd3) ? 8'h00 : 8'h80);
        wr(3'd5, 8'h55);
        if (mode == 2'd2) wr(3'd2, w[7:0]);
        wr(3'd5, (mode == 2'd1) ? 8'h54 : 8'hAA);
        wr(3'd4, (mode == 2'd3) ? 8'h02 : 8'h82);
    endtask

    task automatic watch(output int nb, output int ns, output int pre);
        nb = 0;
        ns = 0;
        pre = -1;
        for (int i = 0; i < STALL + 10; i++) begin
            if (wr_busy) nb++;
            if (stall) begin
                ns++;
                if (pre < 0) pre = nb - 1;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic prot(input logic [12:0] a, input logic [1:0] wp);
        if (wp == 2'd0) return 1'b0;
        if (wp == 2'd1) return a < 13'h0100;
        if (wp == 2'd2) return a < 13'h1000;
        return 1'b1;
    endfunction

    function automatic logic [55:0] packed_buf();
        return {exp_buf[3], exp_buf[2], exp_buf[1], exp_buf[0]};
    endfunction

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] a;
        logic [13:0] w;
        logic [1:0]  wp, mode;
        logic        acc, last, exp_done;
        int          nb, ns, pre, e0, p0;

        for (int k = 0; k < 4; k++) exp_buf[k] = 14'h3FFF;
        exp_done = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", {59'd0, stall, wr_busy, done, mem_erase, mem_prog}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            a    = VEC[i][30:18];
            w    = VEC[i][17:4];
            wp   = VEC[i][3:2];
            mode = VEC[i][1:0];
            wp_cfg = wp;
            acc  = (mode == 2'd0) && !prot(a, wp);
            last = (a[1:0] == 2'b11);
            e0 = n_erase;
            p0 = n_prog;
            do_word(a, w, mode);
            watch(nb, ns, pre);
            if (acc) begin
                exp_buf[a[1:0]] = w;
                exp_done = last;
                if (last) begin
                    check("R6 busy length", 64'(nb), 64'(2 + STALL));
                    check("R6 stall length", 64'(ns), 64'(STALL));
                    check("R6 stall start", 64'(pre), 64'd2);
                    check("R5 erase count", 64'(n_erase - e0), 64'd1);
                    check("R5 prog count", 64'(n_prog - p0), 64'd1);
                    check("R5 erase addr", 64'(er_addr), 64'({a[12:2], 2'b00}));
                    check("R5 prog addr", 64'(pg_addr), 64'({a[12:2], 2'b00}));
                    check("R5/R11 prog data", 64'(pg_data), 64'(packed_buf()));
                end else begin
                    check("R4 busy length", 64'(nb), 64'd2);
                    check("R4 no stall", 64'(ns), 64'd0);
                    check("R4 no command", 64'(n_erase - e0 + n_prog - p0), 64'd0);
                end
            end else begin
                if (mode == 2'd0)
                    check("R8 protected ignored", 64'(nb + n_erase - e0), 64'd0);
                else if (mode == 2'd3)
                    check("R2 select bit required", 64'(nb + n_erase - e0), 64'd0);
                else
                    check("R3 broken unlock ignored", 64'(nb + n_erase - e0), 64'd0);
            end
            check("R7 done flag", 64'(done), 64'(exp_done));
        end

        // R9: data written during the setup window does not alter the word
        wp_cfg = 2'd0;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h55);
        wr(3'd3, 8'h01);
        wr(3'd4, 8'h80);
        wr(3'd5, 8'h55);
        wr(3'd5, 8'hAA);
        wr(3'd4, 8'h82);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h3F);
        exp_buf[0] = 14'h0155;
        repeat (4) @(negedge clk);
        check("R9 busy cleared", 64'(wr_busy), 64'd0);
        do_word(13'h0301, 14'h0002, 2'd0);
        watch(nb, ns, pre);
        exp_buf[1] = 14'h0002;
        do_word(13'h0302, 14'h0003, 2'd0);
        watch(nb, ns, pre);
        exp_buf[2] = 14'h0003;

        // R10: a full unlock and write bit landing in the commit starts nothing
        e0 = n_erase;
        do_word(13'h0303, 14'h0004, 2'd0);
        exp_buf[3] = 14'h0004;
        wr(3'd5, 8'h55);
        wr(3'd5, 8'hAA);
        wr(3'd4, 8'h82);
        watch(nb, ns, pre);
        repeat (10) @(negedge clk);
        check("R10 single erase", 64'(n_erase - e0), 64'd1);
        check("R10 stays idle", 64'(wr_busy), 64'd0);
        check("R9 snapshot data", 64'(pg_data), 64'(packed_buf()));
        check("R5 block addr", 64'(pg_addr), 64'h0300);
        check("R7 done after commit", 64'(done), 64'd1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule